// File: doc/BRIEF.md
# SGRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics DRAM and brings the memory from power-on to an operational state. After a synchronous reset is released it holds the device in a quiet state: clock enable high, all byte masks high, and a no-operation command on the command pins. It keeps that state for a stable-clock interval of at least 200 microseconds. The interval is counted in clock cycles and derived from a clock-frequency parameter.

It then issues a fixed series of commands: one precharge of all banks, a programmable number of auto-refresh commands (at least two), and one mode register set. A parameter selects whether the mode register set comes before or after the refresh commands. The gap after each command is a cycle-count parameter, and only no-operation commands are driven inside a gap. Once the gap after the last command has elapsed, a ready flag goes high and stays high until the next reset.

The mode word is assembled from parameters for burst length, burst type, CAS latency and write burst length. The test-mode bits, the upper address bits and the bank address are forced to zero during the mode register set. The block has no data path: every pin is a plain control output, and the reset input is the only start control.

Top module: `sgram_bringup_seq`

## Requirements
- R1: While reset is low, during the stable interval and inside every gap, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). cke is 1 and every dqm bit is 1 at all times.
- R2: The stable interval is STABLE_CYC = ceil(STABLE_US*CLK_KHZ/1000) cycles. The first non-NOP command appears in the cycle after STABLE_CYC rising edges have been seen with reset high.
- R3: The first command after the interval is a precharge of all banks (cs_n=0, ras_n=0, cas_n=1, we_n=0) with addr[10]=1 and every other address bit at 0. It is issued once per sequence.
- R4: Exactly NUM_REF auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are issued. NUM_REF must be at least 2.
- R5: Exactly one mode register set (all four command pins 0) is issued, with ba=0. The address carries the mode word: addr[2:0] is the burst length code, addr[3] the burst type, addr[6:4] the CAS latency code (001 = 2, 010 = 3), addr[8:7] is 00, addr[9] is the write burst length bit, and addr[10] and above are 0.
- R6: With MRS_FIRST=0 the order is precharge, refreshes, mode set. With MRS_FIRST=1 it is precharge, mode set, refreshes.
- R7: The next command follows exactly TRP_CYC cycles after a precharge, TRC_CYC cycles after a refresh and TMRD_CYC cycles after a mode set.
- R8: ready is low until the gap after the last command has elapsed. It then goes high and stays high, with NOP on the command pins, until reset.
- R9: Asserting reset in the middle of a sequence drops ready and returns the pins to NOP. After release, the whole sequence restarts with a full stable interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset; its release starts the sequence |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Byte masks, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 1 | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | High once initialization is complete |

## Verification
Two configurations run through the whole sequence.
- **Configuration one:** a clock whose cycle count for the interval comes out exact, two refreshes, and the mode set last.
- **Configuration two:** a clock that forces the interval count to round up, three refreshes, and the mode set first. Its mode fields (interleaved bursts, single-bit writes, CAS latency 2) all differ from configuration one.

Together these separate a truncated interval from a rounded-up one, a swapped order from the default one, and a miscounted refresh loop from a correct one. They also catch misplaced or swapped mode-word fields, because every command is checked for its cycle offset from the previous one as well as for its pin code and address. A reset in the middle of a sequence shows whether the block restarts from a full quiet interval or resumes partway through.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

  typedef enum logic [2:0] {
    ST_STABLE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } init_step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pin_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pin_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pin_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  // Address bit that selects "all banks" on a precharge; it is zero on a mode set.
  localparam int unsigned ALL_BANK_BIT = 10;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sgram_mode_word.sv
module sgram_mode_word #(
  parameter int unsigned ADDR_W     = 11,
  parameter logic [2:0]  BL_CODE    = 3'b011,
  parameter bit          BT_ILV     = 1'b0,
  parameter logic [2:0]  CL_CODE    = 3'b010,
  parameter bit          WBL_SINGLE = 1'b0
) (
  output logic [ADDR_W-1:0] word
);

  // Field layout is decoded by the memory: [9] wbl, [8:7] test=00, [6:4] cl, [3] bt, [2:0] bl
  assign word[9:0] = {WBL_SINGLE, 2'b00, CL_CODE, BT_ILV, BL_CODE};

  generate
    if (ADDR_W > 10) begin : g_upper_zero
      assign word[ADDR_W-1:10] = '0;
    end
  endgenerate

endmodule

// File: rtl/sgram_bringup_seq.sv
module sgram_bringup_seq
  import sgram_init_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 200000,
  parameter int unsigned STABLE_US  = 200,
  parameter int unsigned NUM_REF    = 2,
  parameter int unsigned TRP_CYC    = 3,
  parameter int unsigned TRC_CYC    = 7,
  parameter int unsigned TMRD_CYC   = 2,
  parameter bit          MRS_FIRST  = 1'b0,
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DQM_W      = 4,
  parameter logic [2:0]  BL_CODE    = 3'b011,
  parameter bit          BT_ILV     = 1'b0,
  parameter logic [2:0]  CL_CODE    = 3'b010,
  parameter bit          WBL_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int unsigned STABLE_CYC = (STABLE_US * CLK_KHZ + 999) / 1000;
  localparam int unsigned GAP_MAX    = max_of(max_of(TRP_CYC, TRC_CYC), TMRD_CYC);
  localparam int unsigned SPAN       = max_of(STABLE_CYC, GAP_MAX);
  localparam int unsigned TW         = $clog2(SPAN + 1);
  localparam int unsigned RW         = $clog2(NUM_REF + 1);

  init_step_e          step_q, step_d;
  logic                fresh_q;
  logic [RW-1:0]       ref_q;
  logic                expired;
  logic                advance;
  logic [TW-1:0]       load_val;
  logic [ADDR_W-1:0]   mode_word;
  pin_cmd_t            cmd;

  function automatic int unsigned gap_len(input init_step_e s);
    case (s)
      ST_PRE:  return TRP_CYC;
      ST_REF:  return TRC_CYC;
      ST_MRS:  return TMRD_CYC;
      default: return 1;
    endcase
  endfunction

  init_gap_timer #(.W(TW), .RST_VAL(STABLE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (advance),
    .load_val (load_val),
    .expired  (expired)
  );

  sgram_mode_word #(
    .ADDR_W(ADDR_W), .BL_CODE(BL_CODE), .BT_ILV(BT_ILV),
    .CL_CODE(CL_CODE), .WBL_SINGLE(WBL_SINGLE)
  ) u_mode (
    .word (mode_word)
  );

  // Step ordering: precharge first, then refresh loop and mode set in the chosen order
  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_STABLE: step_d = ST_PRE;
      ST_PRE:    step_d = MRS_FIRST ? ST_MRS : ST_REF;
      ST_REF:    if (ref_q == RW'(NUM_REF - 1)) step_d = MRS_FIRST ? ST_DONE : ST_MRS;
                 else                            step_d = ST_REF;
      ST_MRS:    step_d = MRS_FIRST ? ST_REF : ST_DONE;
      default:   step_d = ST_DONE;
    endcase
  end

  assign advance  = expired && (step_q != ST_DONE);
  assign load_val = TW'(gap_len(step_d) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= ST_STABLE;
      fresh_q <= 1'b1;
      ref_q   <= '0;
    end else if (advance) begin
      step_q  <= step_d;
      fresh_q <= 1'b1;
      if (step_q == ST_REF) ref_q <= ref_q + 1'b1;
    end else begin
      fresh_q <= 1'b0;
    end
  end

  // A command appears only in the first cycle of its step; the rest of the step is NOP
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = 1'b0;
    if (fresh_q) begin
      case (step_q)
        ST_PRE: begin
          cmd                = CMD_PRE;
          addr[ALL_BANK_BIT] = 1'b1;
        end
        ST_REF:  cmd = CMD_REF;
        ST_MRS: begin
          cmd  = CMD_MRS;
          addr = mode_word;
        end
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign cke   = 1'b1;
  assign dqm   = '1;
  assign ready = (step_q == ST_DONE);

endmodule

// File: rtl/sgram_init_chk.sv
module sgram_init_chk #(
  parameter int unsigned STABLE_CYC = 40000,
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DQM_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [DQM_W-1:0]  dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);

  localparam int unsigned CW = $clog2(STABLE_CYC + 2) + 1;

  logic [CW-1:0] since_q;
  logic          is_nop, is_pre, is_mrs;

  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)                           since_q <= '0;
    else if (since_q <= CW'(STABLE_CYC))  since_q <= since_q + 1'b1;
  end

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n) cke);            // R1
  AST_DQM_HELD: assert property (@(posedge clk) disable iff (!rst_n) &dqm);           // R1
  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < CW'(STABLE_CYC)) |-> is_nop);                                          // R2
  AST_PRE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == CW'(STABLE_CYC)) |-> (is_pre && addr[10]));                          // R3
  AST_MRS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (!ba && !addr[10] && (addr[8:7] == 2'b00)));                          // R5
  AST_READY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q <= CW'(STABLE_CYC)) |-> !ready);                                         // R8
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);                                                                 // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> is_nop);                                                                // R8

endmodule

bind sgram_bringup_seq sgram_init_chk #(
  .STABLE_CYC (STABLE_CYC),
  .ADDR_W     (ADDR_W),
  .DQM_W      (DQM_W)
) u_init_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cke   (cke),
  .dqm   (dqm),
  .cs_n  (cs_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .we_n  (we_n),
  .ba    (ba),
  .addr  (addr),
  .ready (ready)
);

// File: tb/test_sgram_bringup_seq.sv
`timescale 1ns/1ps
module test_sgram_bringup_seq;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam logic [2:0] K_RST = 3'd0;
  localparam logic [2:0] K_PRE = 3'd1;
  localparam logic [2:0] K_REF = 3'd2;
  localparam logic [2:0] K_MRS = 3'd3;
  localparam logic [2:0] K_RDY = 3'd4;

  // Config A: 200 us at 200000 kHz = 40000 cycles exactly
  // Config B: 200 us at 133333 kHz = 26666.6 -> 26667 cycles
  localparam int STAB_A = 40000;
  localparam int STAB_B = 26667;

  typedef struct packed {
    logic        sel;
    logic [2:0]  kind;
    logic [31:0] gap;
    logic [10:0] addr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, K_RST, 32'd0,      11'h000},
    '{1'b0, K_PRE, STAB_A,     11'h400},
    '{1'b0, K_REF, 32'd3,      11'h000},
    '{1'b0, K_REF, 32'd7,      11'h000},
    '{1'b0, K_MRS, 32'd7,      11'h023},  // bl=011 bt=0 cl=010 wbl=0
    '{1'b0, K_RDY, 32'd2,      11'h000},
    '{1'b1, K_RST, 32'd0,      11'h000},
    '{1'b1, K_PRE, STAB_B,     11'h400},
    '{1'b1, K_MRS, 32'd2,      11'h21A},  // bl=010 bt=1 cl=001 wbl=1
    '{1'b1, K_REF, 32'd3,      11'h000},
    '{1'b1, K_REF, 32'd5,      11'h000},
    '{1'b1, K_REF, 32'd5,      11'h000},
    '{1'b1, K_RDY, 32'd5,      11'h000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  always #2.5 clk = ~clk;

  logic        a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_rdy;
  logic [3:0]  a_dqm;
  logic [10:0] a_addr;
  logic        b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_rdy;
  logic [3:0]  b_dqm;
  logic [10:0] b_addr;

  sgram_bringup_seq #(
    .CLK_KHZ(200000), .STABLE_US(200), .NUM_REF(2), .TRP_CYC(3), .TRC_CYC(7),
    .TMRD_CYC(2), .MRS_FIRST(1'b0), .BL_CODE(3'b011), .BT_ILV(1'b0),
    .CL_CODE(3'b010), .WBL_SINGLE(1'b0)
  ) i_sgram_bringup_seq (
    .clk(clk), .rst_n(rst_n), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs), .ras_n(a_ras),
    .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .ready(a_rdy)
  );

  sgram_bringup_seq #(
    .CLK_KHZ(133333), .STABLE_US(200), .NUM_REF(3), .TRP_CYC(2), .TRC_CYC(5),
    .TMRD_CYC(3), .MRS_FIRST(1'b1), .BL_CODE(3'b010), .BT_ILV(1'b1),
    .CL_CODE(3'b001), .WBL_SINGLE(1'b1)
  ) i_sgram_bringup_seq_b (
    .clk(clk), .rst_n(rst_n), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs), .ras_n(b_ras),
    .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .ready(b_rdy)
  );

  logic [3:0]  o_cmd;
  logic        o_cke, o_ba, o_rdy;
  logic [3:0]  o_dqm;
  logic [10:0] o_addr;

  always_comb begin
    if (sel) begin
      o_cmd = {b_cs, b_ras, b_cas, b_we}; o_cke = b_cke; o_dqm = b_dqm;
      o_ba = b_ba; o_addr = b_addr; o_rdy = b_rdy;
    end else begin
      o_cmd = {a_cs, a_ras, a_cas, a_we}; o_cke = a_cke; o_dqm = a_dqm;
      o_ba = a_ba; o_addr = a_addr; o_rdy = a_rdy;
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit pins_bad = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input logic [2:0] k);
    case (k)
      K_PRE:   return C_PRE;
      K_REF:   return C_REF;
      K_MRS:   return C_MRS;
      default: return C_NOP;
    endcase
  endfunction

  task automatic restart(input logic s);
    sel = s;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(o_cmd == C_NOP && o_cke && o_dqm == 4'hF && !o_rdy, "R1",
          "reset state cmd", int'(o_cmd), int'(C_NOP));
    rst_n = 1'b1;
  endtask

  task automatic walk(input logic [2:0] kind, input int gap, input logic [10:0] exp_addr);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!o_cke || o_dqm != 4'hF) pins_bad = 1'b1;
    end while (o_cmd == C_NOP && !o_rdy && n < gap + 4);
    check(n == gap, (kind == K_PRE) ? "R2" : "R7", "cycles to next event", n, gap);
    if (kind == K_RDY)
      check(o_rdy && o_cmd == C_NOP, "R8", "ready rise cmd", int'(o_cmd), int'(C_NOP));
    else
      check(o_cmd == code_of(kind) && o_addr == exp_addr && !o_ba && !o_rdy,
            (kind == K_PRE) ? "R3" : (kind == K_REF) ? "R4/R6" : "R5/R6",
            "command and address", int'({o_cmd, o_addr}), int'({code_of(kind), exp_addr}));
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].kind == K_RST) restart(VECS[i].sel);
      else walk(VECS[i].kind, int'(VECS[i].gap), VECS[i].addr);
    end
    check(!pins_bad, "R1", "cke/dqm held high during sequences", int'(pins_bad), 0);

    // R8: ready stays high with NOP on the pins (config B is now ready)
    begin
      bit held = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (!o_rdy || o_cmd != C_NOP) held = 1'b0;
      end
      check(held, "R8", "ready sticky with NOP", int'(held), 1);
    end

    // R9: reset in the middle of a sequence restarts with a full interval
    restart(1'b0);
    walk(K_PRE, STAB_A, 11'h400);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!a_rdy && !b_rdy && o_cmd == C_NOP, "R9", "mid-sequence reset state",
          int'({a_rdy, b_rdy}), 0);
    rst_n = 1'b1;
    walk(K_PRE, STAB_A, 11'h400);
    check(!o_rdy, "R9", "ready low after restart precharge", int'(o_rdy), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule